// File: doc/BRIEF.md
# SMBus Packet Error Code Engine

This block computes and checks the one-byte packet error code that may close an SMBus or PMBus transaction. It sits beside the bus byte engine and sees each byte on the wire once, one byte per clock. It keeps a running CRC-8 with generator 0x07 over every byte of a transaction, and the slave address bytes are included. The address that follows a repeated start is treated as just one more byte, so the running value is only cleared by a start-of-transaction strobe.

For a transaction the slave receives, the byte engine gives the number of bytes that the code covers. The byte at that position is taken as the check byte and compared against the running value. A stop that arrives before any check byte marks the transaction as carrying no code, and no error is raised. For a transaction the slave transmits, every byte is folded in, and the current value on `crc_o` is the byte the transmit path appends after the last data byte. The result of each transaction is reported in a single one-cycle pulse. In that pulse a mismatch shows up as an error event for the alert logic.

Top module: `smb_pec_engine`

## Requirements
- R1: The code is CRC-8 with generator 0x07, processed most significant bit first, with no bit reflection and no final XOR. A start strobe (`sof_i`) alone clears the running value to 0x00. For the ASCII bytes "123456789" the result is 0xF4.
- R2: Each byte accepted with `byte_vld_i` updates `crc_o`, and the update is visible from the clock edge that samples the byte. This allows one byte per clock with no gaps.
- R3: On cycles with neither `byte_vld_i` nor `sof_i`, `crc_o` keeps its value.
- R4: A byte that arrives without `sof_i`, such as the read address after a repeated start, is folded into the running value. No earlier byte is discarded.
- R5: In receive mode (`rd_mode_i`=0, sampled at `sof_i`), bytes are numbered from 0. Bytes with an index below `exp_len_i` are folded in. The byte at index `exp_len_i` is the check byte: it is compared with `crc_o` and is not folded in.
- R6: One clock after `eom_i` is sampled, `done_o` is high for exactly one cycle. In that cycle `pec_present_o` is 1 if a check byte was received and 0 otherwise. Outside that cycle `done_o`, `pec_present_o` and `pec_err_o` are 0.
- R7: `pec_err_o` is 1 in the done cycle only when a check byte was received and it differed from the value accumulated before it. A transaction with no check byte never raises `pec_err_o`.
- R8: In transmit mode (`rd_mode_i`=1 at `sof_i`), every byte is folded in, `crc_o` is the code to append, and the done cycle reports `pec_present_o`=0 and `pec_err_o`=0.
- R9: In receive mode, bytes after the check byte change neither `crc_o` nor the reported result.
- R10: A byte given in the same cycle as `sof_i` is the first byte of the new transaction. It is folded into a cleared value, and the earlier state has no effect on it.
- R11: After reset, `crc_o` is 0x00 and `done_o`, `pec_present_o` and `pec_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start of transaction; clears the running code |
| rd_mode_i | input | 1 | Sampled with sof_i: 1 = slave transmits, 0 = slave receives |
| byte_vld_i | input | 1 | A byte is present on byte_i this cycle |
| byte_i | input | 8 | Byte seen on the bus |
| eom_i | input | 1 | End of transaction (stop) |
| exp_len_i | input | LEN_W | Receive mode: number of bytes the code covers |
| crc_o | output | 8 | Running code; the byte to transmit in transmit mode |
| done_o | output | 1 | One-cycle result pulse after eom_i |
| pec_present_o | output | 1 | A check byte was received (valid with done_o) |
| pec_err_o | output | 1 | Check byte mismatch event (valid with done_o) |

## Verification
The hardest cases to reach are those where the byte position and the framing strobes meet. One is a check byte followed by stray bytes before the stop. Another is a byte that arrives in the same cycle as the start strobe, after a transaction that left a non-zero value behind. The stimulus table holds receive transactions whose trailing part is chosen per entry: absent, correct, corrupted, or followed by extra bytes. Directed sequences chain transactions back to back without an idle clear and send the first byte together with the start strobe. All expected codes come from a separate byte-wise model in the bench.

// File: rtl/smb_pec_pkg.sv
package smb_pec_pkg;
  localparam logic [7:0] CRC_POLY = 8'h07;

  // MSB-first byte update, unreflected
  function automatic logic [7:0] crc8_upd(input logic [7:0] crc, input logic [7:0] d,
                                          input logic [7:0] poly);
    logic [7:0] c;
    c = crc ^ d;
    for (int k = 0; k < 8; k++) begin
      c = c[7] ? ({c[6:0], 1'b0} ^ poly) : {c[6:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/smb_pec_crc_reg.sv
module smb_pec_crc_reg
  import smb_pec_pkg::*;
#(
  parameter logic [7:0] POLY = CRC_POLY
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  logic [7:0] crc_q;
  logic [7:0] base;
  logic [7:0] nxt;

  assign base = clr_i ? 8'h00 : crc_q;

  always_comb nxt = crc8_upd(base, data_i, POLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= 8'h00;
    else if (upd_i) crc_q <= nxt;
    else if (clr_i) crc_q <= 8'h00;
  end

  assign crc_o = crc_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !upd_i) |=> $stable(crc_q)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !upd_i) |=> (crc_q == 8'h00)); // R1
endmodule

// File: rtl/smb_pec_frame_ctl.sv
module smb_pec_frame_ctl #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             rd_mode_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             eom_i,
  input  logic [LEN_W-1:0] exp_len_i,
  input  logic [7:0]       crc_cur_i,
  output logic             fold_o,
  output logic             done_o,
  output logic             pec_present_o,
  output logic             pec_err_o
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, idx;
  logic             rd_q, seen_q, bad_q;
  logic             rd_eff, seen_eff, bad_eff;
  logic             is_chk, seen_nxt, bad_nxt;
  logic [7:0]       ref_crc;
  logic [CNT_W-1:0] len_ext;

  assign len_ext  = {1'b0, exp_len_i};
  assign idx      = sof_i ? '0 : cnt_q;
  assign rd_eff   = sof_i ? rd_mode_i : rd_q;
  assign seen_eff = sof_i ? 1'b0 : seen_q;
  assign bad_eff  = sof_i ? 1'b0 : bad_q;
  assign ref_crc  = sof_i ? 8'h00 : crc_cur_i;

  assign fold_o   = byte_vld_i && (rd_eff || (idx < len_ext));
  assign is_chk   = byte_vld_i && !rd_eff && (idx == len_ext);
  assign seen_nxt = seen_eff || is_chk;
  assign bad_nxt  = bad_eff || (is_chk && (byte_i != ref_crc));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      seen_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      rd_q   <= rd_eff;
      seen_q <= seen_nxt;
      bad_q  <= bad_nxt;
      if (byte_vld_i && idx != CNT_MAX) cnt_q <= idx + 1'b1;
      else                              cnt_q <= idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      pec_present_o <= 1'b0;
      pec_err_o     <= 1'b0;
    end else begin
      done_o        <= eom_i;
      pec_present_o <= eom_i && seen_nxt;
      pec_err_o     <= eom_i && seen_nxt && bad_nxt;
    end
  end

  AST_ERR_NEEDS_PEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pec_err_o |-> (pec_present_o && done_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eom_i |=> (!done_o && !pec_present_o && !pec_err_o)); // R6
  AST_RD_NO_PEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eom_i && rd_eff) |=> (!pec_present_o && !pec_err_o)); // R8
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sof_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R9
endmodule

// File: rtl/smb_pec_engine.sv
module smb_pec_engine
  import smb_pec_pkg::*;
#(
  parameter int         LEN_W = 8,
  parameter logic [7:0] POLY  = CRC_POLY
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             rd_mode_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             eom_i,
  input  logic [LEN_W-1:0] exp_len_i,
  output logic [7:0]       crc_o,
  output logic             done_o,
  output logic             pec_present_o,
  output logic             pec_err_o
);
  logic fold;

  smb_pec_frame_ctl #(.LEN_W(LEN_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sof_i        (sof_i),
    .rd_mode_i    (rd_mode_i),
    .byte_vld_i   (byte_vld_i),
    .byte_i       (byte_i),
    .eom_i        (eom_i),
    .exp_len_i    (exp_len_i),
    .crc_cur_i    (crc_o),
    .fold_o       (fold),
    .done_o       (done_o),
    .pec_present_o(pec_present_o),
    .pec_err_o    (pec_err_o)
  );

  smb_pec_crc_reg #(.POLY(POLY)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sof_i),
    .upd_i (fold),
    .data_i(byte_i),
    .crc_o (crc_o)
  );

  AST_FOLD_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_vld_i && !sof_i) |=> $stable(crc_o)); // R3
endmodule

// File: tb/smb_pec_engine_tb.sv
module smb_pec_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // [31] rd, [30:29] kind 0 none/1 good/2 bad, [28:24] extra, [23:16] n, [7:0] seed
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    32'h2003_0010, 32'h4003_0055, 32'h0004_00A7, 32'h8005_0031,
    32'h2202_00C3, 32'h2001_0002, 32'h8001_00FE
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sof_i = 0, rd_mode_i = 0, byte_vld_i = 0, eom_i = 0;
  logic [7:0] byte_i = 0, exp_len_i = 0;
  logic [7:0] crc_o;
  logic done_o, pec_present_o, pec_err_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  smb_pec_engine u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(sof_i), .rd_mode_i(rd_mode_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .eom_i(eom_i), .exp_len_i(exp_len_i),
    .crc_o(crc_o), .done_o(done_o), .pec_present_o(pec_present_o), .pec_err_o(pec_err_o)
  );

  function automatic logic [7:0] mdl(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    byte_vld_i = 1; byte_i = b;
    @(negedge clk_i);
    byte_vld_i = 0;
  endtask

  task automatic start(input logic rd);
    sof_i = 1; rd_mode_i = rd;
    @(negedge clk_i);
    sof_i = 0;
  endtask

  task automatic stop();
    eom_i = 1;
    @(negedge clk_i);
    eom_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] m, b, prev;
    logic [7:0] s9 [0:8];
    s9 = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    repeat (3) @(negedge clk_i);
    chk("R11 crc", crc_o, 8'h00);
    chk("R11 done", {7'd0, done_o}, 8'd0);
    chk("R11 present", {7'd0, pec_present_o}, 8'd0);
    chk("R11 err", {7'd0, pec_err_o}, 8'd0);
    rst_ni = 1;
    @(negedge clk_i);

    // table walk: R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      logic rd;
      int kind, extra, n;
      rd = VEC[v][31]; kind = int'(VEC[v][30:29]); extra = int'(VEC[v][28:24]);
      n = int'(VEC[v][23:16]);
      exp_len_i = 8'(n);
      m = 8'h00;
      start(rd);
      for (int i = 0; i < n; i++) begin
        b = VEC[v][7:0] + 8'(i * 59) ^ 8'(i << 4);
        put(b);
        m = mdl(m, b);
        chk(rd ? "R8 crc per byte" : "R2 crc per byte", crc_o, m);
      end
      if (!rd && kind != 0) begin
        put(kind == 1 ? m : (m ^ 8'h5A));
        chk("R5 check byte not folded", crc_o, m);
        for (int e = 0; e < extra; e++) put(8'h3C + 8'(e));
        if (extra != 0) chk("R9 extra bytes ignored", crc_o, m);
      end
      stop();
      chk("R6 done", {7'd0, done_o}, 8'd1);
      chk(rd ? "R8 present" : "R6 present", {7'd0, pec_present_o},
          (!rd && kind != 0) ? 8'd1 : 8'd0);
      chk(rd ? "R8 err" : "R7 err", {7'd0, pec_err_o},
          (!rd && kind == 2) ? 8'd1 : 8'd0);
      @(negedge clk_i);
      chk("R6 done single cycle", {5'd0, done_o, pec_present_o, pec_err_o}, 8'd0);
    end

    // R1 known answer, read mode
    start(1'b1);
    for (int i = 0; i < 9; i++) put(s9[i]);
    chk("R1 known answer", crc_o, 8'hF4);
    repeat (3) @(negedge clk_i);
    chk("R3 idle hold", crc_o, 8'hF4);
    stop();

    // R10 byte together with sof after a nonzero value
    sof_i = 1; rd_mode_i = 1; byte_vld_i = 1; byte_i = s9[0];
    @(negedge clk_i);
    sof_i = 0; byte_vld_i = 0;
    for (int i = 1; i < 9; i++) put(s9[i]);
    chk("R10 sof with byte", crc_o, 8'hF4);
    stop();

    // R1 sof alone clears
    start(1'b0);
    chk("R1 sof clears", crc_o, 8'h00);

    // R4 repeated-start read address included
    start(1'b1);
    m = 8'h00;
    foreach (s9[i]) if (i < 5) begin
      b = (i == 0) ? 8'hB0 : (i == 1) ? 8'h8B : (i == 2) ? 8'hB1 : (i == 3) ? 8'h34 : 8'h12;
      put(b);
      m = mdl(m, b);
    end
    prev = mdl(mdl(mdl(mdl(8'h00, 8'hB0), 8'h8B), 8'h34), 8'h12);
    chk("R4 read address folded", crc_o, m);
    chk("R4 differs without it", (crc_o == prev) ? 8'd1 : 8'd0, 8'd0);
    stop();

    // R7 good check byte computed from the wire, write with addresses
    exp_len_i = 8'd3;
    start(1'b0);
    put(8'hB0); put(8'h01); put(8'h80);
    put(mdl(mdl(mdl(8'h00, 8'hB0), 8'h01), 8'h80));
    stop();
    chk("R7 good pec no err", {6'd0, pec_present_o, pec_err_o}, 8'b10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule